// File: doc/BRIEF.md
# Framebuffer Scan-Out Pixel Serializer

This block turns a framebuffer held in an internal dual-port word memory into a stream of RGB pixels for a display. Software-side writes arrive on their own clock. Each write stores one 48-bit word. The video side runs on an unrelated video clock and is steered by strobes from an external sync-timing generator: a frame strobe, a line strobe, a display-enable and the two syncs. Each memory word carries sixteen pixels. The three colour planes sit in separate 16-bit lanes, one bit per pixel per colour.

Every frame starts reading at a programmable base word. Each new line begins one line stride further on, and the address wraps modulo the memory depth. Inside a line, the read side fetches words ahead into a single-word holding buffer. A per-plane shift register is reloaded from that buffer, so pixels leave back to back while display-enable is high. The shifter halts while display-enable is low, and the outputs are blanked during that time.

The write port follows valid/ready. Ready is held high at all times, because a write never stalls, so a word is stored in every cycle in which valid is high. The pixel output is not a stream and cannot apply back-pressure. It is paced only by display-enable, and the timing generator has to leave enough lead time after each line strobe.

Top module: `fb_scanout`

## Requirements
- R1: `wr_ready` is always high, and every write clock cycle with `wr_valid` high stores `wr_data` at word `wr_addr`. Later scan-out returns that word.
- R2: In a word, bits [15:0] are the red plane, bits [31:16] are the green plane and bits [47:32] are the blue plane. Pixel k of the word (k = 0..15) uses bit 15-k of each plane, so the most significant bit of each plane goes out first. `r_out`, `g_out` and `b_out` carry one bit each.
- R3: `de_out`, `hs_out` and `vs_out` equal `de_in`, `hs_in` and `vs_in` delayed by exactly one video clock.
- R4: Whenever `de_out` is low, `r_out`, `g_out` and `b_out` are all zero.
- R5: The first `line_start` after a `frame_start` reads from the value `base_addr` had in the `frame_start` cycle.
- R6: Every later `line_start` in the same frame starts one stride further on, where the stride is the `line_stride` value sampled at `frame_start`. The sum wraps modulo 2^ADDR_W.
- R7: Inside a line, active pixel n comes from word (line start + n/16) mod 2^ADDR_W. The pixels are continuous with no gaps between words, provided the first `de_in` of the line comes at least 4 video clocks after `line_start`.
- R8: Changes to `base_addr` or `line_stride` after `frame_start` have no effect until the next `frame_start`.
- R9: While `vid_rst_n` is low, `de_out`, `hs_out`, `vs_out` and the RGB outputs are all zero, whatever the inputs do.
- R10: A stretch with `de_in` low in the middle of a line freezes the pixel position. The next active pixel is the one that would have come next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, asynchronous to `vid_clk` |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 3*PLANE_W | Word to store (blue, green, red lanes) |
| vid_clk | input | 1 | Video clock |
| vid_rst_n | input | 1 | Active-low asynchronous reset of the video side |
| base_addr | input | ADDR_W | First word of a frame, sampled at `frame_start` |
| line_stride | input | ADDR_W | Word step between lines, sampled at `frame_start` |
| frame_start | input | 1 | One-cycle frame strobe, at least one cycle before the first `line_start` |
| line_start | input | 1 | One-cycle line strobe |
| de_in | input | 1 | Display-enable from the timing generator |
| hs_in | input | 1 | Horizontal sync from the timing generator |
| vs_in | input | 1 | Vertical sync from the timing generator |
| de_out | output | 1 | Delayed display-enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| r_out | output | 1 | Red pixel bit |
| g_out | output | 1 | Green pixel bit |
| b_out | output | 1 | Blue pixel bit |

## Verification
Several properties are checked on every video clock: the one-cycle delay of enable and syncs, blanking while enable is low, quiet outputs in reset, the hold of the sampled base and stride outside frame strobes, and that the shifter is never empty while enable is high. The checks that depend on content can only come from the bench scenarios. These are the plane and bit order, base and stride addressing including wrap-around, word stepping every sixteen pixels, and resumption after mid-line enable gaps. The bench compares each pixel against a model of the memory it wrote.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // number of colour planes in one memory word (R, G, B)
  localparam int NPLANES = 3;

  // plane index positions inside a word, lowest lane first
  localparam int PLANE_RED   = 0;
  localparam int PLANE_GREEN = 1;
  localparam int PLANE_BLUE  = 2;

  typedef struct packed {
    logic b;
    logic g;
    logic r;
  } rgb_t;
endpackage

// File: rtl/fb_dpram.sv
module fb_dpram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 48,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered read: data appears one read clock after the request
  always_ff @(posedge rd_clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fb_line_addr.sv
module fb_line_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] stride_in,
  output logic [ADDR_W-1:0] next_line,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] stride_q
);
  logic              first_q;
  logic [ADDR_W-1:0] line_q;
  logic              first_eff;
  logic [ADDR_W-1:0] base_eff;

  // a frame strobe in the same cycle as a line strobe still selects the base
  always_comb begin
    first_eff = first_q | frame_start;
    base_eff  = frame_start ? base_in : base_q;
    next_line = first_eff ? base_eff : ADDR_W'(line_q + stride_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      line_q   <= '0;
      first_q  <= 1'b1;
    end else begin
      if (frame_start) begin
        base_q   <= base_in;
        stride_q <= stride_in;
        first_q  <= 1'b1;
      end
      if (line_start) begin
        line_q  <= next_line;
        first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fb_prefetch.sv
module fb_prefetch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              take,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_word
);
  logic active_q;
  logic inflight_q;

  // one read outstanding at most; the buffer is refilled as soon as it empties
  assign rd_en = active_q && !buf_full && !inflight_q && !line_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      inflight_q <= 1'b0;
      buf_full   <= 1'b0;
      buf_word   <= '0;
      rd_addr    <= '0;
    end else if (line_start) begin
      active_q   <= 1'b1;
      inflight_q <= 1'b0;
      buf_full   <= 1'b0;
      rd_addr    <= start_addr;
    end else begin
      inflight_q <= rd_en;
      if (rd_en) rd_addr <= ADDR_W'(rd_addr + 1'b1);
      if (inflight_q) begin
        buf_word <= rd_data;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fb_shifter.sv
module fb_shifter
  import fb_pkg::*;
#(
  parameter int PLANE_W = 16,
  localparam int DATA_W = NPLANES * PLANE_W,
  localparam int CNT_W  = $clog2(PLANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_word,
  output logic              take,
  output logic [CNT_W-1:0]  cnt,
  output logic              de_out,
  output logic              hs_out,
  output logic              vs_out,
  output rgb_t              pix_out
);
  logic [NPLANES-1:0] msb;
  logic               shift_en;

  // reload when empty, or on the last pixel so the next word follows with no gap
  assign take     = buf_full && !line_start &&
                    ((cnt == '0) || (de_in && cnt == CNT_W'(1)));
  assign shift_en = de_in && (cnt != '0);

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [PLANE_W-1:0] sh_q;
    assign msb[p] = sh_q[PLANE_W-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (take)     sh_q <= buf_word[p*PLANE_W +: PLANE_W];
      else if (shift_en) sh_q <= {sh_q[PLANE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      de_out  <= 1'b0;
      hs_out  <= 1'b0;
      vs_out  <= 1'b0;
      pix_out <= '0;
    end else begin
      if (line_start)    cnt <= '0;
      else if (take)     cnt <= CNT_W'(PLANE_W);
      else if (shift_en) cnt <= CNT_W'(cnt - 1'b1);
      de_out    <= de_in;
      hs_out    <= hs_in;
      vs_out    <= vs_in;
      pix_out.r <= de_in & msb[PLANE_RED];
      pix_out.g <= de_in & msb[PLANE_GREEN];
      pix_out.b <= de_in & msb[PLANE_BLUE];
    end
  end
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PLANE_W = 16,
  localparam int DATA_W = NPLANES * PLANE_W,
  localparam int CNT_W  = $clog2(PLANE_W + 1)
) (
  input  logic              wr_clk,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vid_clk,
  input  logic              vid_rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] line_stride,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic              de_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              r_out,
  output logic              g_out,
  output logic              b_out
);
  logic [ADDR_W-1:0] next_line;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stride_q;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              buf_full;
  logic [DATA_W-1:0] buf_word;
  logic              take;
  logic [CNT_W-1:0]  sh_cnt;
  rgb_t              pix;

  assign wr_ready = 1'b1;

  fb_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_valid & wr_ready),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .rd_clk (vid_clk),
    .re     (rd_en),
    .raddr  (rd_addr),
    .rdata  (rd_data)
  );

  fb_line_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (vid_clk),
    .rst_n       (vid_rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .base_in     (base_addr),
    .stride_in   (line_stride),
    .next_line   (next_line),
    .base_q      (base_q),
    .stride_q    (stride_q)
  );

  fb_prefetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk        (vid_clk),
    .rst_n      (vid_rst_n),
    .line_start (line_start),
    .start_addr (next_line),
    .take       (take),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .buf_full   (buf_full),
    .buf_word   (buf_word)
  );

  fb_shifter #(.PLANE_W(PLANE_W)) u_shift (
    .clk        (vid_clk),
    .rst_n      (vid_rst_n),
    .line_start (line_start),
    .de_in      (de_in),
    .hs_in      (hs_in),
    .vs_in      (vs_in),
    .buf_full   (buf_full),
    .buf_word   (buf_word),
    .take       (take),
    .cnt        (sh_cnt),
    .de_out     (de_out),
    .hs_out     (hs_out),
    .vs_out     (vs_out),
    .pix_out    (pix)
  );

  assign r_out = pix.r;
  assign g_out = pix.g;
  assign b_out = pix.b;
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              vid_clk,
  input logic              vid_rst_n,
  input logic              frame_start,
  input logic              de_in,
  input logic              hs_in,
  input logic              vs_in,
  input logic              de_out,
  input logic              hs_out,
  input logic              vs_out,
  input logic              r_out,
  input logic              g_out,
  input logic              b_out,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] stride_q,
  input logic [CNT_W-1:0]  sh_cnt
);
  // R3: enable and syncs trail their inputs by one clock
  a_r3_delay: assert property (@(posedge vid_clk) disable iff (!vid_rst_n)
    1'b1 |=> (de_out == $past(de_in)) && (hs_out == $past(hs_in)) &&
             (vs_out == $past(vs_in)));

  // R4: no colour while enable is low
  a_r4_blank: assert property (@(posedge vid_clk) disable iff (!vid_rst_n)
    !de_out |-> !(r_out | g_out | b_out));

  // R9: reset leaves all outputs quiet
  a_r9_reset_quiet: assert property (@(posedge vid_clk)
    !vid_rst_n |=> !(de_out | hs_out | vs_out | r_out | g_out | b_out));

  // R8: sampled base and stride only move on a frame strobe
  a_r8_hold: assert property (@(posedge vid_clk) disable iff (!vid_rst_n)
    !frame_start |=> $stable(base_q) && $stable(stride_q));

  // R7: the shifter never runs dry while pixels are requested
  a_r7_no_underrun: assert property (@(posedge vid_clk) disable iff (!vid_rst_n)
    de_in |-> (sh_cnt != '0));
endmodule

bind fb_scanout fb_scanout_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .vid_clk     (vid_clk),
  .vid_rst_n   (vid_rst_n),
  .frame_start (frame_start),
  .de_in       (de_in),
  .hs_in       (hs_in),
  .vs_in       (vs_in),
  .de_out      (de_out),
  .hs_out      (hs_out),
  .vs_out      (vs_out),
  .r_out       (r_out),
  .g_out       (g_out),
  .b_out       (b_out),
  .base_q      (base_q),
  .stride_q    (stride_q),
  .sh_cnt      (sh_cnt)
);

// File: tb/fb_scanout_test.sv
module fb_scanout_test;
  localparam int AW    = 8;
  localparam int PW    = 16;
  localparam int WW    = 3 * PW;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          vid_clk = 1'b0;
  logic          vid_rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] line_stride = '0;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          de_in = 1'b0;
  logic          hs_in = 1'b0;
  logic          vs_in = 1'b0;
  logic          de_out, hs_out, vs_out, r_out, g_out, b_out;

  always #10 vid_clk = ~vid_clk;  // 50 MHz
  always #7  wr_clk  = ~wr_clk;

  fb_scanout #(.ADDR_W(AW), .PLANE_W(PW)) uut (
    .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .vid_clk(vid_clk), .vid_rst_n(vid_rst_n),
    .base_addr(base_addr), .line_stride(line_stride),
    .frame_start(frame_start), .line_start(line_start),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
    .r_out(r_out), .g_out(g_out), .b_out(b_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [WW-1:0] mem_m [DEPTH];
  string pix_tag = "R2";

  // bench model of the read side
  logic [AW-1:0] m_base = '0, m_stride = '0, m_line = '0;
  bit            m_first = 1'b1;
  int            m_pix = 0;
  logic          exp_de = 0, exp_hs = 0, exp_vs = 0;
  logic [2:0]    exp_rgb = '0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] model_pixel(input logic [AW-1:0] line, input int pix);
    logic [AW-1:0] w;
    int b;
    w = AW'(line + AW'(pix / PW));
    b = PW - 1 - (pix % PW);
    return {mem_m[w][2*PW + b], mem_m[w][PW + b], mem_m[w][b]};
  endfunction

  task automatic vcycle(input logic de, input logic hs, input logic vs,
                        input logic fs, input logic ls);
    @(negedge vid_clk);
    check("R3 de", de_out, exp_de);
    check("R3 hs", hs_out, exp_hs);
    check("R3 vs", vs_out, exp_vs);
    check(exp_de ? pix_tag : "R4", {b_out, g_out, r_out}, exp_rgb);
    de_in = de; hs_in = hs; vs_in = vs; frame_start = fs; line_start = ls;
    if (fs) begin
      m_base = base_addr; m_stride = line_stride; m_first = 1'b1;
    end
    if (ls) begin
      m_line  = m_first ? m_base : AW'(m_line + m_stride);
      m_first = 1'b0;
      m_pix   = 0;
    end
    exp_de = de; exp_hs = hs; exp_vs = vs;
    if (de) begin
      exp_rgb = model_pixel(m_line, m_pix);
      m_pix++;
    end else begin
      exp_rgb = '0;
    end
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge wr_clk);
    check("R1 ready", wr_ready, 1);
    mem_m[a] = d;
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [WW-1:0] rand_word();
    return WW'({$urandom(), $urandom()});
  endfunction

  task automatic do_line(input int npix, input int hole_pct);
    int p;
    vcycle(0, 0, 0, 0, 1);
    for (int g = 0; g < 3 + int'($urandom % 3); g++) vcycle(0, 1, 0, 0, 0);
    p = 0;
    while (p < npix) begin
      if (int'($urandom % 100) < hole_pct) vcycle(0, 0, 0, 0, 0);
      else begin
        vcycle(1, 0, 0, 0, 0);
        p++;
      end
    end
    vcycle(0, 0, 0, 0, 0);
  endtask

  task automatic do_frame(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input int nlines, input int npix, input int hole_pct,
                          input bit disturb);
    base_addr = b; line_stride = s;
    vcycle(0, 0, 1, 1, 0);
    vcycle(0, 0, 1, 0, 0);
    if (disturb) begin
      // R8: new register values mid-frame must not be used
      base_addr = AW'($urandom); line_stride = AW'($urandom);
    end
    for (int l = 0; l < nlines; l++) do_line(npix, hole_pct);
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset holds outputs low even with active inputs
    de_in = 1; hs_in = 1; vs_in = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge vid_clk);
      check("R9 reset", {de_out, hs_out, vs_out, r_out, g_out, b_out}, 0);
    end
    de_in = 0; hs_in = 0; vs_in = 0;
    @(negedge vid_clk);
    vid_rst_n = 1'b1;

    // R1: fill the memory through the write port
    for (int i = 0; i < DEPTH; i++) wr_word(AW'(i), rand_word());
    // R2: directed plane and bit order word
    wr_word(8'd5, {16'h8001, 16'h00FF, 16'hF0F0});

    pix_tag = "R2";
    do_frame(8'd5, 8'd1, 1, 16, 0, 0);

    pix_tag = "R5";
    do_frame(8'd0, 8'd2, 3, 32, 0, 0);

    // R6: stride wraps past the top of the memory
    pix_tag = "R6";
    do_frame(8'd250, 8'd10, 4, 48, 0, 0);

    // R7: long line crossing many words, minimum lead time
    pix_tag = "R7";
    do_frame(8'd100, 8'd7, 2, 128, 0, 0);

    // R10: enable holes in the middle of lines
    pix_tag = "R10";
    do_frame(8'd40, 8'd3, 3, 64, 30, 0);

    // R8: registers disturbed after the frame strobe
    pix_tag = "R8";
    for (int f = 0; f < 4; f++)
      do_frame(AW'($urandom), AW'($urandom), 2 + int'($urandom % 3),
               16 + int'($urandom % 49), int'($urandom % 20), 1);

    // R1: overwrite words between frames and read them back
    pix_tag = "R1";
    for (int i = 0; i < 8; i++) wr_word(AW'(60 + i), rand_word());
    do_frame(8'd60, 8'd2, 4, 32, 10, 0);

    for (int f = 0; f < 6; f++) begin
      pix_tag = "R7";
      do_frame(AW'($urandom), AW'($urandom), 1 + int'($urandom % 4),
               1 + int'($urandom % 80), int'($urandom % 25), f[0]);
    end
    vcycle(0, 0, 0, 0, 0);
    vcycle(0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge vid_clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule